// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C/SMBus target that runs on a fast system clock and oversamples SCL and SDA. Both lines are synchronised and then glitch-filtered before any edge or bus condition is decoded. The block recognises its 7-bit address. The upper four bits of that address are a parameter and the lower three come from strap pins, so eight copies can share one bus. Once addressed, it turns bus traffic into single-byte accesses on a small internal register bus that reaches four 8-bit registers.

In a write transaction, the first byte after the address is a command byte. That byte becomes a pointer, and the pointer keeps its value until a later command byte or a reset replaces it. Data bytes that follow in the same transaction all rewrite the selected register, because the pointer never advances. The pointer values select these registers:
- 0: input port (read-only)
- 1: output port
- 2: polarity inversion
- 3: direction configuration

A read transaction returns the register that the pointer currently selects. Every byte is acknowledged, including command values above 3. With such a pointer, writes do nothing and reads return all ones. SDA is driven only as an open-drain pull-down enable, and clock stretching is never used.

Top module: `i2c_regbus_target`

## Requirements
- R1: The address byte is acknowledged (SDA pulled low during the ninth SCL clock) only when its seven upper bits equal {ADDR_HI, strap_a}. On a mismatch the target drives nothing until the next START.
- R2: In a matched write transaction, every received byte is acknowledged on its ninth clock, including command bytes of any value from 0 to 255.
- R3: The first byte after a write address is stored as the register pointer, and reg_addr shows its two low bits. Pointer 0 selects the input port, 1 the output port, 2 polarity inversion and 3 direction configuration.
- R4: A data byte received while the pointer is 1, 2 or 3 produces a one-cycle reg_we, with reg_wdata equal to the byte and reg_addr equal to the pointer. Further bytes in the same transaction rewrite the same register.
- R5: A data byte received while the pointer is 0 or greater than 3 is acknowledged but produces no reg_we.
- R6: In a read transaction, each byte is captured from reg_rdata when the pointer is 3 or less, with reg_re pulsing for one cycle, and it is shifted out MSB first. A pointer above 3 returns 0xFF and produces no reg_re.
- R7: A controller ACK after a read byte starts another read of the same register. A controller NACK makes the target release SDA until the next START.
- R8: The pointer keeps its value across STOP and repeated START, and only reset clears it to 0.
- R9: A level change on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.
- R10: A START or repeated START at any point restarts address reception and discards a partly received byte. A STOP returns the target to idle.
- R11: During and after reset, sda_oe, reg_we and reg_re are low, and reg_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a | input | 3 | Low three address bits |
| reg_addr | output | 2 | Register select (pointer low bits) |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data for reg_addr |
| reg_re | output | 1 | One-cycle register read strobe |

## Verification
START/STOP detection and bit shifting watch the same filtered lines, so a bus condition can land in the clock where a data bit would otherwise be processed. The bench provokes this by cutting off a data byte after five bits with a repeated START. It then expects no write strobe and a fresh address phase, and confirms through a read that the selected register still holds its earlier value. A second collision comes from glitches placed inside the SCL-high phase of every bit: a filter fault would turn these into extra edges or false STOP conditions in the same clocks as valid bits, and the write that follows would then be lost.

// File: rtl/i2c_regbus_target.sv
module i2c_regbus_target #(
  parameter logic [3:0] ADDR_HI  = 4'b0100,
  parameter int         FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_a,
  output logic [1:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       reg_re
);

  localparam int CW = $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } st_t;

  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic s1, s2, fl;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        fl  <= 1'b1;
        cnt <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 != fl) begin
          if (cnt == CW'(FILT_LEN - 1)) begin
            fl  <= s2;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
    assign filt[g] = fl;
  end

  logic scl_f, sda_f, scl_d, sda_d;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr_q, rd_byte;
  logic       first, rw;
  logic       ptr_ok;

  assign ptr_ok    = (ptr_q[7:2] == 6'd0);
  assign rd_byte   = ptr_ok ? reg_rdata : 8'hFF;
  assign reg_addr  = ptr_q[1:0];
  assign reg_wdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr_q  <= '0;
      first  <= 1'b0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        first  <= 1'b1;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == {ADDR_HI, strap_a}) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                reg_re <= ptr_ok;
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              st     <= ST_WACK;
              if (first) begin
                ptr_q <= shreg;
                first <= 1'b0;
              end else if (ptr_ok && ptr_q[1:0] != 2'd0) begin
                reg_we <= 1'b1;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_f) st <= ST_IDLE;
            end else if (scl_fall) begin
              bitcnt <= '0;
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              reg_re <= ptr_ok;
              st     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_f); // R2
  AST_WE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R4
  AST_WE_NOT_RO:   assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> reg_addr != 2'd0); // R5
  AST_RE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re); // R6
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) st == ST_IDLE |-> !sda_oe); // R7
  AST_STOP_FREE:   assert property (@(posedge clk) disable iff (!rst_n) stop_c |=> !sda_oe); // R10
  AST_WE_RE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re)); // R4

endmodule

// File: tb/sim_i2c_regbus_target.sv
module sim_i2c_regbus_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;
  localparam logic [3:0] AHI = 4'b0100;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MYADDR = {AHI, STRAP};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0;
  logic sda_oe, reg_we, reg_re;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] bank [4];
  logic [7:0] mb [4];
  int ptr_m = 0;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [9:0] weq [$];
  logic [1:0] req [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  i2c_regbus_target #(.ADDR_HI(AHI), .FILT_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a(STRAP), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re));

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && reg_we) bank[reg_addr] <= reg_wdata;

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      if (weq.size() == 0) chk(0, "R5 unexpected reg_we", {reg_addr, reg_wdata}, 0);
      else begin
        logic [9:0] e;
        e = weq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R4 write strobe", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_re) begin
      if (req.size() == 0) chk(0, "R6 unexpected reg_re", reg_addr, 0);
      else begin
        logic [1:0] e;
        e = req.pop_front();
        chk(reg_addr == e, "R6 read strobe", reg_addr, e);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1;
    if (glitch) begin
      tick(10); scl_m = 1'b0; tick(3); scl_m = 1'b1;
      tick(12); sda_m = ~b; tick(3); sda_m = b; tick(12);
    end else tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack);
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wr_addr(string tag);
    logic a;
    start_c();
    send_byte({MYADDR, 1'b0}, a);
    chk(a == 1'b0, tag, a, 0);
  endtask

  task automatic wr_cmd(logic [7:0] c);
    logic a;
    send_byte(c, a);
    chk(a == 1'b0, "R2 command ack", a, 0);
    ptr_m = c;
    chk(reg_addr == c[1:0], "R3 pointer on reg_addr", reg_addr, c[1:0]);
  endtask

  task automatic wr_data(logic [7:0] d);
    logic a;
    if (ptr_m >= 1 && ptr_m <= 3) begin
      weq.push_back({2'(ptr_m), d});
      mb[ptr_m] = d;
    end
    send_byte(d, a);
    chk(a == 1'b0, "R2 data ack", a, 0);
  endtask

  task automatic rd_addr();
    logic a;
    start_c();
    if (ptr_m < 4) req.push_back(2'(ptr_m));
    send_byte({MYADDR, 1'b1}, a);
    chk(a == 1'b0, "R1 read address ack", a, 0);
  endtask

  task automatic rd_data(logic nack, string tag);
    logic [7:0] d, e;
    if (!nack && ptr_m < 4) req.push_back(2'(ptr_m));
    recv_byte(nack, d);
    e = (ptr_m < 4) ? mb[ptr_m] : 8'hFF;
    chk(d == e, tag, d, e);
  endtask

  task automatic drained(string tag);
    tick(10);
    chk(weq.size() == 0 && req.size() == 0, tag, weq.size() + req.size(), 0);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    bank[0] = 8'h3C; bank[1] = 8'h00; bank[2] = 8'h00; bank[3] = 8'hFF;
    for (int i = 0; i < 4; i++) mb[i] = bank[i];
    tick(5);
    chk(sda_oe == 0 && reg_we == 0 && reg_re == 0 && reg_addr == 0, "R11 in reset", {sda_oe, reg_we, reg_re, reg_addr}, 0);
    rst_n = 1'b1;
    tick(20);
    chk(sda_oe == 0 && reg_addr == 0, "R11 after reset", {sda_oe, reg_addr}, 0);

    start_c(); send_byte({MYADDR ^ 7'h01, 1'b0}, a);
    chk(a == 1'b1, "R1 low-bit mismatch nack", a, 1);
    send_byte(8'h00, a);
    chk(a == 1'b1, "R1 silent until START", a, 1);
    stop_c();
    start_c(); send_byte({MYADDR ^ 7'h20, 1'b0}, a);
    chk(a == 1'b1, "R1 high-bit mismatch nack", a, 1);
    stop_c();

    wr_addr("R1 write address ack"); wr_cmd(8'h01); wr_data(8'hA5); stop_c();
    drained("R4 output port write");

    wr_addr("R1 write address ack"); wr_cmd(8'h02);
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); stop_c();
    drained("R4 no auto-increment");

    wr_addr("R1 write address ack"); wr_cmd(8'h03); wr_data(8'h0F); stop_c();
    drained("R4 config write");

    wr_addr("R1 write address ack"); wr_cmd(8'h00); wr_data(8'h55); stop_c();
    drained("R5 read-only pointer 0");
    rd_addr(); rd_data(1'b1, "R6 read input port"); stop_c();
    drained("R6 strobes");

    wr_addr("R1 write address ack"); wr_cmd(8'h01); stop_c();
    rd_addr(); rd_data(1'b0, "R8 pointer kept after STOP"); rd_data(1'b1, "R7 repeat read after ACK");
    recv_byte(1'b1, d);
    chk(d == 8'hFF, "R7 released after NACK", d, 8'hFF);
    stop_c();
    drained("R7 strobe count");

    wr_addr("R1 write address ack"); wr_cmd(8'h07); wr_data(8'h99); stop_c();
    drained("R5 pointer above 3 write");
    rd_addr(); rd_data(1'b0, "R6 pointer above 3 reads FF"); rd_data(1'b1, "R6 pointer above 3 reads FF"); stop_c();
    drained("R6 no strobe above 3");

    wr_addr("R1 write address ack"); wr_cmd(8'h03);
    rd_addr(); rd_data(1'b1, "R8 pointer across repeated START"); stop_c();
    drained("R8 strobes");

    wr_addr("R1 write address ack"); wr_cmd(8'h02);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    rd_addr(); rd_data(1'b1, "R10 partial byte discarded"); stop_c();
    drained("R10 no write from aborted byte");

    glitch = 1'b1;
    wr_addr("R9 address through glitches"); wr_cmd(8'h01); wr_data(8'h5A); stop_c();
    glitch = 1'b0;
    drained("R9 write through glitches");
    rd_addr(); rd_data(1'b1, "R9 readback after glitches"); stop_c();
    drained("R9 strobes");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(150000);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule